// File: doc/BRIEF.md
# Bidirectional Shift Register with Four Modes

A register of parameterised width whose next value is chosen each clock by a 2-bit mode input. The four modes shift the contents one place towards the most significant end, load a parallel word, keep the contents unchanged, or shift one place towards the least significant end. Every bit is a D flip-flop behind its own 4:1 multiplexer, and the mode bits drive the select lines of that multiplexer.

The two end bits differ from the middle bits. On a left shift the least significant bit takes a separate serial input, because it has no lower neighbour. On a right shift the most significant bit takes a second serial input, because it has no upper neighbour. The bit pushed out at the far end of a shift is discarded. A synchronous active-high clear takes priority over every mode.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `srst` is 1 at a rising edge of `clk`, `q` becomes all zeros after that edge.
- R2: With `mode` = 2'b01 (load), `q` takes the value of `par_in` after the edge.
- R3: With `mode` = 2'b10 (hold), `q` keeps its previous value after the edge.
- R4: With `mode` = 2'b00 (shift left), each bit `q[i]` for i >= 1 takes the old `q[i-1]`.
- R5: On a shift left, `q[0]` takes `fill_lsb` and the old `q[WIDTH-1]` is lost.
- R6: With `mode` = 2'b11 (shift right), each bit `q[i]` for i <= WIDTH-2 takes the old `q[i+1]`.
- R7: On a shift right, `q[WIDTH-1]` takes `fill_msb` and the old `q[0]` is lost.
- R8: `srst` overrides every mode, and a load with an all-ones `par_in` during reset still gives all zeros.
- R9: In load and hold modes, `fill_lsb` and `fill_msb` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear, active high |
| mode | input | 2 | 00 shift left, 01 load, 10 hold, 11 shift right |
| par_in | input | WIDTH | Parallel load word |
| fill_lsb | input | 1 | Serial bit entering bit 0 on a left shift |
| fill_msb | input | 1 | Serial bit entering the top bit on a right shift |
| q | output | WIDTH | Register contents |

## Verification
Every result, whether clear, load, hold or shift, appears on `q` one clock edge after the inputs that select it, because a single register stage lies between the inputs and `q`. The bench drives inputs on the falling edge, waits for the next rising edge, and samples `q` 2 ns later, before any other input changes. A 4-bit instance is swept over all 16 start values, all four modes and all four serial-input pairs. Each start value is first placed in the register with a load, and the expected result is then computed with shifts and masks.

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             fill_lsb,
  input  logic             fill_msb,
  output logic [WIDTH-1:0] q
);
  localparam logic [1:0] MODE_SHL  = 2'b00;
  localparam logic [1:0] MODE_LOAD = 2'b01;
  localparam logic [1:0] MODE_HOLD = 2'b10;
  localparam logic [1:0] MODE_SHR  = 2'b11;
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_low, from_high;
    if (i == 0) begin : g_lsb
      assign from_low = fill_lsb;
    end else begin : g_low
      assign from_low = q[i-1];
    end
    if (i == TOP) begin : g_msb
      assign from_high = fill_msb;
    end else begin : g_high
      assign from_high = q[i+1];
    end
    assign nxt[i] = mode[1] ? (mode[0] ? from_high : q[i])
                            : (mode[0] ? par_in[i] : from_low);
  end

  always_ff @(posedge clk) begin
    if (srst) q <= '0;
    else      q <= nxt;
  end

  AST_CLEAR:     assert property (@(posedge clk) srst |=> q == '0); // R1
  AST_LOAD:      assert property (@(posedge clk) disable iff (srst) mode == MODE_LOAD |=> q == $past(par_in)); // R2
  AST_HOLD:      assert property (@(posedge clk) disable iff (srst) mode == MODE_HOLD |=> $stable(q)); // R3
  AST_SHL_BODY:  assert property (@(posedge clk) disable iff (srst) mode == MODE_SHL |=> q[TOP:1] == $past(q[TOP-1:0])); // R4
  AST_SHL_FILL:  assert property (@(posedge clk) disable iff (srst) mode == MODE_SHL |=> q[0] == $past(fill_lsb)); // R5
  AST_SHR_BODY:  assert property (@(posedge clk) disable iff (srst) mode == MODE_SHR |=> q[TOP-1:0] == $past(q[TOP:1])); // R6
  AST_SHR_FILL:  assert property (@(posedge clk) disable iff (srst) mode == MODE_SHR |=> q[TOP] == $past(fill_msb)); // R7
endmodule

// File: tb/bidir_shift_reg_bench.sv
module bidir_shift_reg_bench;
  localparam int W = 4;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic [1:0] mode = 2'b10;
  logic [W-1:0] par_in = '0;
  logic fill_lsb = 1'b0, fill_msb = 1'b0;
  logic [W-1:0] q;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) u_bidir_shift_reg (
    .clk(clk), .srst(srst), .mode(mode), .par_in(par_in),
    .fill_lsb(fill_lsb), .fill_msb(fill_msb), .q(q));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] d,
                      input logic sl, input logic sr);
    @(negedge clk);
    srst = r; mode = m; par_in = d; fill_lsb = sl; fill_msb = sr;
    @(posedge clk);
    #2;
  endtask

  initial begin
    logic [W-1:0] exp;
    step(1'b1, 2'b10, '0, 1'b0, 1'b0);
    check("R1 reset clears", q, '0);
    step(1'b1, 2'b01, MASK, 1'b1, 1'b1);
    check("R8 reset over load", q, '0);
    step(1'b1, 2'b00, MASK, 1'b1, 1'b1);
    check("R8 reset over shift", q, '0);
    for (int s = 0; s < (1 << W); s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int f = 0; f < 4; f++) begin
          step(1'b0, 2'b01, W'(s), f[0], f[1]);
          check((f != 0) ? "R9 load ignores fills" : "R2 load", q, W'(s));
          case (m)
            0: exp = ((W'(s) << 1) | W'(f[0])) & MASK;
            1: exp = ~W'(s);
            2: exp = W'(s);
            default: exp = (W'(s) >> 1) | (W'(f[1]) << (W-1));
          endcase
          step(1'b0, 2'(m), ~W'(s), f[0], f[1]);
          case (m)
            0: begin
              check("R4 shift left", q, exp);
              check("R5 lsb fill", W'(q[0]), W'(f[0]));
            end
            1: check((f != 0) ? "R9 load ignores fills" : "R2 load", q, exp);
            2: check((f != 0) ? "R9 hold ignores fills" : "R3 hold", q, exp);
            default: begin
              check("R6 shift right", q, exp);
              check("R7 msb fill", W'(q[W-1]), W'(f[1]));
            end
          endcase
        end
      end
    end
    step(1'b0, 2'b01, 4'b1001, 1'b0, 1'b0);
    for (int k = 0; k < W; k++) step(1'b0, 2'b00, '0, 1'b1, 1'b0);
    check("R5 msb dropped after full left pass", q, MASK);
    for (int k = 0; k < W; k++) step(1'b0, 2'b11, '0, 1'b0, 1'b0);
    check("R7 lsb dropped after full right pass", q, '0);
    step(1'b1, 2'b10, '0, 1'b0, 1'b0);
    check("R1 clear from hold", q, '0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule